// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block drives the control side of an RGB display panel. It divides the internal clock into a pixel clock whose period is a programmable number of internal cycles. It steps a horizontal and a vertical position counter through four regions in both directions: the visible area, the front porch, the sync pulse and the back porch. From those counters it decodes line sync, frame sync, data enable and chip select. It also produces the framebuffer byte address of every visible pixel, together with a one-cycle strobe. The address is built from a line pointer plus the pixel column, scaled by a pixel width of one or two bytes.

The line pointer is reloaded from a frame base input on one of two sync events, chosen by a mode bit. After each visible line it advances by a programmable stride of up to 0xFFF bytes. Every timing and addressing setting is copied into a shadow set at the start of each frame, so a change takes effect only on the next frame. The one exception is pin polarity, which acts at once.

The address strobe is a valid-only stream with no ready. A panel cannot be stalled, so the consumer must accept each address in the cycle it is offered. The strobe comes at most once per pixel period, and the period is at least two cycles. The active-position counters are exposed as plain outputs.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, every panel pin is at its inactive level, `fb_addr_valid` is 0, and both positions are 0. The configuration inputs present on that first clock edge after release become the first frame's settings, and `fb_base` is loaded into the line pointer.
- R2: Each pixel lasts `cfg_pclk_period` cycles, numbered 0 to period-1.
  - `fb_addr_valid` pulses in cycle 0 of each visible pixel.
  - The pixel clock is active from cycle `cfg_setup` through cycle `cfg_setup+cfg_hold-1`.
  - Legal settings satisfy setup ≥ 1, hold ≥ 1 and setup+hold ≤ period.
- R3: `col_pos` counts 0 to total-1, advancing once per pixel.
  - The total is active+front+sync+back.
  - The line sync is active for `cfg_h_sync` pixels, starting at column active+front.
- R4: `row_pos` advances when the column wraps from its last value to 0.
  - The frame sync is active for `cfg_v_sync` rows, starting at row active+front.
  - Both sync widths and both active sizes are at least 1.
- R5: Data enable is active exactly when the column is below the horizontal active size and the row is below the vertical active size.
- R6: Chip select is active on every row below the vertical active size, including that row's porch and sync pixels.
- R7: Each of the five panel pins has its own polarity bit: 1 means active high and 0 means active low. Polarity takes effect immediately.
- R8: Changes to geometry, pixel clock, stride, pixel width or latch mode apply from the first pixel of the next frame. The current frame keeps its old settings.
- R9: For a visible pixel, `fb_addr` equals the line pointer plus the column times 1 when `cfg_two_byte` is 0, or times 2 when it is 1, modulo 2^24.
- R10: After each visible row except the last, the line pointer grows by the 12-bit `cfg_stride`, so visible row r of a frame starts at base + r·stride.
- R11: With `cfg_base_on_hsync` = 0, the line pointer reloads from `fb_base` when the frame sync begins, and that value serves the next frame. A change of `fb_base` at any other time has no effect on the addresses issued.
- R12: With `cfg_base_on_hsync` = 1, the line pointer reloads from `fb_base` when each line sync begins, so every row starts at the base sampled during the previous row's sync start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_active | input | 12 | Visible pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch, pixels |
| cfg_h_sync | input | 12 | Line sync width, pixels |
| cfg_h_back | input | 12 | Horizontal back porch, pixels |
| cfg_v_active | input | 12 | Visible rows per frame |
| cfg_v_front | input | 12 | Vertical front porch, rows |
| cfg_v_sync | input | 12 | Frame sync width, rows |
| cfg_v_back | input | 12 | Vertical back porch, rows |
| cfg_pclk_period | input | 8 | Internal cycles per pixel |
| cfg_setup | input | 8 | Cycles from pixel start to the active clock edge |
| cfg_hold | input | 8 | Cycles the pixel clock stays active |
| cfg_stride | input | 12 | Bytes added to the line pointer per visible row |
| cfg_two_byte | input | 1 | 1: two bytes per pixel, 0: one byte |
| cfg_base_on_hsync | input | 1 | 1: reload base on line sync, 0: on frame sync |
| cfg_pol_cs | input | 1 | Chip select polarity (1 = active high) |
| cfg_pol_pclk | input | 1 | Pixel clock polarity |
| cfg_pol_de | input | 1 | Data enable polarity |
| cfg_pol_hsync | input | 1 | Line sync polarity |
| cfg_pol_vsync | input | 1 | Frame sync polarity |
| fb_base | input | 24 | Frame base byte address |
| lcd_cs | output | 1 | Panel chip select |
| lcd_pclk | output | 1 | Pixel clock |
| lcd_de | output | 1 | Data enable |
| lcd_hsync | output | 1 | Line sync |
| lcd_vsync | output | 1 | Frame sync |
| fb_addr | output | 24 | Byte address of the current visible pixel |
| fb_addr_valid | output | 1 | One-cycle strobe qualifying `fb_addr` |
| col_pos | output | 12 | Current column counter |
| row_pos | output | 12 | Current row counter |

## Verification
The hardest situation to reach from the ports is a setting or base change that lands mid-frame. The old values must survive until the frame wraps, and the line pointer must carry correctly across a switch between the two reload modes. The stimulus keeps the geometries tiny, a few pixels by a few rows, so a frame boundary comes every few hundred cycles. It then rewrites the whole configuration, the base and the polarities at random cycles that fall mostly inside frames. A reference model computes every pin and address from the cycle count within the frame. Directed cases cover zero porches, the shortest pixel period, the largest stride and address wrap.

// File: rtl/lcd_tgen_pkg.sv
`timescale 1ns/1ps
package lcd_tgen_pkg;
  localparam int CNT_W    = 12;
  localparam int DIV_W    = 8;
  localparam int ADDR_W   = 24;
  localparam int STRIDE_W = 12;
  localparam int N_AXES   = 2;
  localparam int AX_H     = 0;
  localparam int AX_V     = 1;

  localparam logic [CNT_W-1:0] RST_H_ACTIVE = CNT_W'(320);
  localparam logic [CNT_W-1:0] RST_H_FRONT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_H_SYNC   = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_H_BACK   = CNT_W'(29);
  localparam logic [CNT_W-1:0] RST_V_ACTIVE = CNT_W'(240);
  localparam logic [CNT_W-1:0] RST_V_FRONT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_V_SYNC   = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_V_BACK   = CNT_W'(4);
  localparam logic [DIV_W-1:0] RST_PERIOD   = DIV_W'(5);
  localparam logic [DIV_W-1:0] RST_SETUP    = DIV_W'(1);
  localparam logic [DIV_W-1:0] RST_HOLD     = DIV_W'(1);

  typedef struct packed {
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] front;
    logic [CNT_W-1:0] sync;
    logic [CNT_W-1:0] back;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t             h;
    axis_cfg_t             v;
    logic [DIV_W-1:0]      period;
    logic [DIV_W-1:0]      setup;
    logic [DIV_W-1:0]      hold;
    logic [STRIDE_W-1:0]   stride;
    logic                  two_byte;
    logic                  base_on_hsync;
  } frame_cfg_t;

  function automatic logic pin_level(input logic active, input logic active_high);
    return active_high ? active : !active;
  endfunction
endpackage

// File: rtl/lcd_axis_ctr.sv
`timescale 1ns/1ps
module lcd_axis_ctr
  import lcd_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output logic [CNT_W-1:0] pos,
  output logic             at_end,
  output logic             at_last_active,
  output logic             at_pre_sync,
  output logic             in_active,
  output logic             in_sync
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic [SUM_W-1:0] pos_x;
  logic [SUM_W-1:0] sync_lo;
  logic [SUM_W-1:0] sync_hi;
  logic [SUM_W-1:0] total;

  assign pos_x   = SUM_W'(pos);
  assign sync_lo = SUM_W'(cfg.active) + SUM_W'(cfg.front);
  assign sync_hi = sync_lo + SUM_W'(cfg.sync);
  assign total   = sync_hi + SUM_W'(cfg.back);

  assign at_end         = (pos_x == total - ONE);
  assign at_last_active = (pos_x == SUM_W'(cfg.active) - ONE);
  assign at_pre_sync    = (pos_x == sync_lo - ONE);
  assign in_active      = (pos_x < SUM_W'(cfg.active));
  assign in_sync        = (pos_x >= sync_lo) && (pos_x < sync_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (step) begin
      pos <= at_end ? '0 : pos + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lcd_pclk_div.sv
`timescale 1ns/1ps
module lcd_pclk_div
  import lcd_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  input  logic [DIV_W-1:0] setup,
  input  logic [DIV_W-1:0] hold,
  output logic             tick,
  output logic             pix_start,
  output logic             pclk_act
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W:0]   release_at;

  assign tick       = run && (phase_q == period - DIV_W'(1));
  assign pix_start  = run && (phase_q == '0);
  assign release_at = {1'b0, setup} + {1'b0, hold};
  assign pclk_act   = run && (phase_q >= setup) && ({1'b0, phase_q} < release_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/lcd_fb_addr.sv
`timescale 1ns/1ps
module lcd_fb_addr
  import lcd_tgen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prime,
  input  logic                tick,
  input  logic                base_on_hsync,
  input  logic                ev_hsync,
  input  logic                ev_vsync,
  input  logic                line_done,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                two_byte,
  input  logic [CNT_W-1:0]    col,
  output logic [ADDR_W-1:0]   addr
);
  logic [ADDR_W-1:0] line_ptr;
  logic [ADDR_W-1:0] col_off;
  logic              reload;

  assign reload  = base_on_hsync ? ev_hsync : ev_vsync;
  assign col_off = two_byte ? ADDR_W'({col, 1'b0}) : ADDR_W'(col);
  assign addr    = line_ptr + col_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ptr <= '0;
    end else if (prime) begin
      line_ptr <= base;
    end else if (tick) begin
      if (reload) begin
        line_ptr <= base;
      end else if (line_done) begin
        line_ptr <= line_ptr + ADDR_W'(stride);
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
  import lcd_tgen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cfg_h_active,
  input  logic [CNT_W-1:0]    cfg_h_front,
  input  logic [CNT_W-1:0]    cfg_h_sync,
  input  logic [CNT_W-1:0]    cfg_h_back,
  input  logic [CNT_W-1:0]    cfg_v_active,
  input  logic [CNT_W-1:0]    cfg_v_front,
  input  logic [CNT_W-1:0]    cfg_v_sync,
  input  logic [CNT_W-1:0]    cfg_v_back,
  input  logic [DIV_W-1:0]    cfg_pclk_period,
  input  logic [DIV_W-1:0]    cfg_setup,
  input  logic [DIV_W-1:0]    cfg_hold,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic                cfg_two_byte,
  input  logic                cfg_base_on_hsync,
  input  logic                cfg_pol_cs,
  input  logic                cfg_pol_pclk,
  input  logic                cfg_pol_de,
  input  logic                cfg_pol_hsync,
  input  logic                cfg_pol_vsync,
  input  logic [ADDR_W-1:0]   fb_base,
  output logic                lcd_cs,
  output logic                lcd_pclk,
  output logic                lcd_de,
  output logic                lcd_hsync,
  output logic                lcd_vsync,
  output logic [ADDR_W-1:0]   fb_addr,
  output logic                fb_addr_valid,
  output logic [CNT_W-1:0]    col_pos,
  output logic [CNT_W-1:0]    row_pos
);
  frame_cfg_t cfg_in;
  frame_cfg_t shadow;
  logic       run_q;
  logic       prime;
  logic       tick;
  logic       pix_start;
  logic       pclk_act;
  logic       frame_end;

  axis_cfg_t        ax_cfg   [N_AXES];
  logic [CNT_W-1:0] ax_pos   [N_AXES];
  logic [N_AXES-1:0] ax_step;
  logic [N_AXES-1:0] ax_end;
  logic [N_AXES-1:0] ax_last;
  logic [N_AXES-1:0] ax_pre;
  logic [N_AXES-1:0] ax_act;
  logic [N_AXES-1:0] ax_sync;

  assign cfg_in.h.active      = cfg_h_active;
  assign cfg_in.h.front       = cfg_h_front;
  assign cfg_in.h.sync        = cfg_h_sync;
  assign cfg_in.h.back        = cfg_h_back;
  assign cfg_in.v.active      = cfg_v_active;
  assign cfg_in.v.front       = cfg_v_front;
  assign cfg_in.v.sync        = cfg_v_sync;
  assign cfg_in.v.back        = cfg_v_back;
  assign cfg_in.period        = cfg_pclk_period;
  assign cfg_in.setup         = cfg_setup;
  assign cfg_in.hold          = cfg_hold;
  assign cfg_in.stride        = cfg_stride;
  assign cfg_in.two_byte      = cfg_two_byte;
  assign cfg_in.base_on_hsync = cfg_base_on_hsync;

  assign prime     = !run_q;
  assign frame_end = tick && ax_end[AX_H] && ax_end[AX_V];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow.h             <= '{RST_H_ACTIVE, RST_H_FRONT, RST_H_SYNC, RST_H_BACK};
      shadow.v             <= '{RST_V_ACTIVE, RST_V_FRONT, RST_V_SYNC, RST_V_BACK};
      shadow.period        <= RST_PERIOD;
      shadow.setup         <= RST_SETUP;
      shadow.hold          <= RST_HOLD;
      shadow.stride        <= '0;
      shadow.two_byte      <= 1'b0;
      shadow.base_on_hsync <= 1'b0;
    end else if (prime || frame_end) begin
      shadow <= cfg_in;
    end
  end

  lcd_pclk_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .period    (shadow.period),
    .setup     (shadow.setup),
    .hold      (shadow.hold),
    .tick      (tick),
    .pix_start (pix_start),
    .pclk_act  (pclk_act)
  );

  assign ax_cfg[AX_H]  = shadow.h;
  assign ax_cfg[AX_V]  = shadow.v;
  assign ax_step[AX_H] = tick;
  assign ax_step[AX_V] = tick && ax_end[AX_H];

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    lcd_axis_ctr u_axis (
      .clk            (clk),
      .rst_n          (rst_n),
      .step           (ax_step[a]),
      .cfg            (ax_cfg[a]),
      .pos            (ax_pos[a]),
      .at_end         (ax_end[a]),
      .at_last_active (ax_last[a]),
      .at_pre_sync    (ax_pre[a]),
      .in_active      (ax_act[a]),
      .in_sync        (ax_sync[a])
    );
  end

  lcd_fb_addr u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .prime         (prime),
    .tick          (tick),
    .base_on_hsync (shadow.base_on_hsync),
    .ev_hsync      (ax_pre[AX_H]),
    .ev_vsync      (ax_end[AX_H] && ax_pre[AX_V]),
    .line_done     (ax_last[AX_H] && ax_act[AX_V] && !ax_last[AX_V]),
    .base          (fb_base),
    .stride        (shadow.stride),
    .two_byte      (shadow.two_byte),
    .col           (ax_pos[AX_H]),
    .addr          (fb_addr)
  );

  assign lcd_cs        = pin_level(run_q && ax_act[AX_V], cfg_pol_cs);
  assign lcd_pclk      = pin_level(pclk_act, cfg_pol_pclk);
  assign lcd_de        = pin_level(run_q && ax_act[AX_H] && ax_act[AX_V], cfg_pol_de);
  assign lcd_hsync     = pin_level(run_q && ax_sync[AX_H], cfg_pol_hsync);
  assign lcd_vsync     = pin_level(run_q && ax_sync[AX_V], cfg_pol_vsync);
  assign fb_addr_valid = pix_start && ax_act[AX_H] && ax_act[AX_V];
  assign col_pos       = ax_pos[AX_H];
  assign row_pos       = ax_pos[AX_V];
endmodule

// File: rtl/lcd_timing_gen_chk.sv
`timescale 1ns/1ps
module lcd_timing_gen_chk
  import lcd_tgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pol_cs,
  input logic             cfg_pol_pclk,
  input logic             cfg_pol_de,
  input logic             cfg_pol_hsync,
  input logic             lcd_cs,
  input logic             lcd_pclk,
  input logic             lcd_de,
  input logic             lcd_hsync,
  input logic             fb_addr_valid,
  input logic [CNT_W-1:0] col_pos,
  input logic [CNT_W-1:0] row_pos
);
  logic de_on, cs_on, hs_on, pclk_on;
  assign de_on   = (lcd_de == cfg_pol_de);
  assign cs_on   = (lcd_cs == cfg_pol_cs);
  assign hs_on   = (lcd_hsync == cfg_pol_hsync);
  assign pclk_on = (lcd_pclk == cfg_pol_pclk);

  AST_VALID_INSIDE_DE: assert property (@(posedge clk) disable iff (!rst_n) fb_addr_valid |-> de_on); // R5
  AST_VALID_ONE_PER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n) fb_addr_valid |=> !fb_addr_valid); // R2
  AST_PCLK_IDLE_AT_PIXEL_START: assert property (@(posedge clk) disable iff (!rst_n) fb_addr_valid |-> !pclk_on); // R2
  AST_COL_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n) (col_pos != $past(col_pos)) |-> (col_pos == $past(col_pos) + CNT_W'(1) || col_pos == '0)); // R3
  AST_ROW_MOVES_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (row_pos != $past(row_pos)) |-> (col_pos == '0)); // R4
  AST_HSYNC_OUTSIDE_DE: assert property (@(posedge clk) disable iff (!rst_n) hs_on |-> !de_on); // R3
  AST_CS_COVERS_DE: assert property (@(posedge clk) disable iff (!rst_n) de_on |-> cs_on); // R6
endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_pol_cs    (cfg_pol_cs),
  .cfg_pol_pclk  (cfg_pol_pclk),
  .cfg_pol_de    (cfg_pol_de),
  .cfg_pol_hsync (cfg_pol_hsync),
  .lcd_cs        (lcd_cs),
  .lcd_pclk      (lcd_pclk),
  .lcd_de        (lcd_de),
  .lcd_hsync     (lcd_hsync),
  .fb_addr_valid (fb_addr_valid),
  .col_pos       (col_pos),
  .row_pos       (row_pos)
);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;
  import lcd_tgen_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_h_active, cfg_h_front, cfg_h_sync, cfg_h_back;
  logic [CNT_W-1:0] cfg_v_active, cfg_v_front, cfg_v_sync, cfg_v_back;
  logic [DIV_W-1:0] cfg_pclk_period, cfg_setup, cfg_hold;
  logic [STRIDE_W-1:0] cfg_stride;
  logic cfg_two_byte, cfg_base_on_hsync;
  logic [4:0] pols;
  logic [ADDR_W-1:0] fb_base;
  logic lcd_cs, lcd_pclk, lcd_de, lcd_hsync, lcd_vsync, fb_addr_valid;
  logic [ADDR_W-1:0] fb_addr;
  logic [CNT_W-1:0] col_pos, row_pos;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front), .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
    .cfg_v_active(cfg_v_active), .cfg_v_front(cfg_v_front), .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back),
    .cfg_pclk_period(cfg_pclk_period), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_stride(cfg_stride), .cfg_two_byte(cfg_two_byte), .cfg_base_on_hsync(cfg_base_on_hsync),
    .cfg_pol_cs(pols[0]), .cfg_pol_pclk(pols[1]), .cfg_pol_de(pols[2]),
    .cfg_pol_hsync(pols[3]), .cfg_pol_vsync(pols[4]), .fb_base(fb_base),
    .lcd_cs(lcd_cs), .lcd_pclk(lcd_pclk), .lcd_de(lcd_de), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .fb_addr(fb_addr), .fb_addr_valid(fb_addr_valid), .col_pos(col_pos), .row_pos(row_pos)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic chk_en = 1'b0, done = 1'b0;

  // Reference model: cycle index within the frame plus the frame's settings.
  logic mrun = 1'b0;
  int mk, gHA, gHF, gHS, gHB, gVA, gVF, gVS, gVB, gP, gSU, gHO, gST;
  logic gTWO, gHSM;
  logic [ADDR_W-1:0] m_latched, m_frame;
  int m_ht, m_vt, m_n, m_h, m_v;

  task automatic take_settings();
    gHA = int'(cfg_h_active); gHF = int'(cfg_h_front); gHS = int'(cfg_h_sync); gHB = int'(cfg_h_back);
    gVA = int'(cfg_v_active); gVF = int'(cfg_v_front); gVS = int'(cfg_v_sync); gVB = int'(cfg_v_back);
    gP = int'(cfg_pclk_period); gSU = int'(cfg_setup); gHO = int'(cfg_hold); gST = int'(cfg_stride);
    gTWO = cfg_two_byte; gHSM = cfg_base_on_hsync;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrun = 1'b0;
    end else if (!mrun) begin
      mrun = 1'b1; mk = 0; take_settings();
      m_latched = fb_base; m_frame = fb_base;
    end else begin
      m_ht = gHA + gHF + gHS + gHB; m_vt = gVA + gVF + gVS + gVB;
      m_n = mk / gP; m_h = m_n % m_ht; m_v = m_n / m_ht;
      if ((mk % gP) == gP - 1) begin
        if (gHSM && m_h == gHA + gHF - 1) m_latched = fb_base;
        if (!gHSM && m_h == m_ht - 1 && m_v == gVA + gVF - 1) m_latched = fb_base;
      end
      if (mk == gP * m_ht * m_vt - 1) begin
        mk = 0; take_settings(); m_frame = m_latched;
      end else begin
        mk = mk + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  function automatic logic lvl(input logic act, input logic pol);
    return act ? pol : !pol;
  endfunction

  always @(negedge clk) begin
    if (chk_en) begin
      if (!mrun) begin
        check("R1 cs idle", 32'(lcd_cs), 32'(!pols[0]));
        check("R1 pclk idle", 32'(lcd_pclk), 32'(!pols[1]));
        check("R1 de idle", 32'(lcd_de), 32'(!pols[2]));
        check("R1 hsync idle", 32'(lcd_hsync), 32'(!pols[3]));
        check("R1 vsync idle", 32'(lcd_vsync), 32'(!pols[4]));
        check("R1 valid idle", 32'(fb_addr_valid), 32'd0);
        check("R1 positions", {8'd0, col_pos, row_pos}, 32'd0);
      end else begin
        int ht, n, h, v, ph;
        logic de, vld;
        logic [ADDR_W-1:0] ea;
        ht = gHA + gHF + gHS + gHB;
        ph = mk % gP; n = mk / gP; h = n % ht; v = n / ht;
        de = (h < gHA) && (v < gVA);
        vld = de && (ph == 0);
        check("R6 R7 cs", 32'(lcd_cs), 32'(lvl(v < gVA, pols[0])));
        check("R2 R7 pclk", 32'(lcd_pclk), 32'(lvl(ph >= gSU && ph < gSU + gHO, pols[1])));
        check("R5 R7 de", 32'(lcd_de), 32'(lvl(de, pols[2])));
        check("R3 R7 hsync", 32'(lcd_hsync), 32'(lvl(h >= gHA + gHF && h < gHA + gHF + gHS, pols[3])));
        check("R4 R7 vsync", 32'(lcd_vsync), 32'(lvl(v >= gVA + gVF && v < gVA + gVF + gVS, pols[4])));
        check("R2 valid", 32'(fb_addr_valid), 32'(vld));
        check("R3 R8 col", 32'(col_pos), 32'(h));
        check("R4 R8 row", 32'(row_pos), 32'(v));
        if (vld) begin
          if (gHSM) begin
            ea = m_latched + ADDR_W'(h << gTWO);
            check("R9 R12 addr", 32'(fb_addr), 32'(ea));
          end else begin
            ea = m_frame + ADDR_W'(v * gST) + ADDR_W'(h << gTWO);
            check("R9 R10 R11 addr", 32'(fb_addr), 32'(ea));
          end
        end
      end
    end
  end

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int ha, hf, hs, hb, va, vf, vs, vb, p, su, ho, st,
                         input logic two, hsm, input logic [ADDR_W-1:0] base, input logic [4:0] pl);
    cfg_h_active = CNT_W'(ha); cfg_h_front = CNT_W'(hf); cfg_h_sync = CNT_W'(hs); cfg_h_back = CNT_W'(hb);
    cfg_v_active = CNT_W'(va); cfg_v_front = CNT_W'(vf); cfg_v_sync = CNT_W'(vs); cfg_v_back = CNT_W'(vb);
    cfg_pclk_period = DIV_W'(p); cfg_setup = DIV_W'(su); cfg_hold = DIV_W'(ho);
    cfg_stride = STRIDE_W'(st); cfg_two_byte = two; cfg_base_on_hsync = hsm;
    fb_base = base; pols = pl;
  endtask

  task automatic rand_cfg();
    int p, su;
    p = rnd(2, 6); su = rnd(1, p - 1);
    set_cfg(rnd(1, 6), rnd(0, 2), rnd(1, 3), rnd(0, 2), rnd(1, 4), rnd(0, 2), rnd(1, 2), rnd(0, 2),
            p, su, rnd(1, p - su), rnd(0, 4095), 1'($urandom), 1'($urandom),
            ADDR_W'($urandom), 5'($urandom));
  endtask

  task automatic restart();
    rst_n = 1'b0; step(3); rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1BADB002));
    // Directed: no porches, shortest pixel, one-byte pixels (R1 R2 R3 R4).
    set_cfg(4, 0, 1, 0, 3, 0, 1, 0, 2, 1, 1, 16, 1'b0, 1'b0, 24'h001000, 5'b00000);
    step(2); chk_en = 1'b1; step(2); restart(); step(1500);
    // Directed: largest stride, address wrap, all active high (R7 R9 R10).
    set_cfg(3, 2, 2, 1, 2, 1, 2, 1, 5, 2, 3, 4095, 1'b1, 1'b0, 24'hFFFF00, 5'b11111);
    restart(); step(1500);
    // Directed: line-sync reload with a base moved mid-frame (R12).
    set_cfg(5, 1, 1, 2, 4, 1, 1, 1, 3, 1, 2, 32, 1'b1, 1'b1, 24'h000400, 5'b10101);
    restart(); step(400);
    fb_base = 24'h00A000; step(400);
    // Directed: frame-sync reload with a base moved inside the frame (R11).
    set_cfg(4, 1, 1, 1, 3, 1, 1, 1, 2, 1, 1, 100, 1'b0, 1'b0, 24'h002000, 5'b00000);
    restart(); step(30);
    fb_base = 24'h003000; step(600);
    // Random: settings rewritten at arbitrary points inside frames (R8).
    for (int s = 0; s < 14; s++) begin
      rand_cfg(); restart();
      for (int c = 0; c < 6; c++) begin
        step(rnd(150, 500));
        if ($urandom % 3 == 0) fb_base = ADDR_W'($urandom);
        else rand_cfg();
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule